// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the register front end of a small LCD display controller. It sits on a 32-bit bus with word addresses inside a 4 KB window. It holds four timing words, the frame base addresses for the upper and lower panels, a control word, an interrupt mask and a raw interrupt status. Its outputs drive the rest of the display pipeline directly.

While the controller is enabled, a frame-tick state machine raises two interrupt causes once per frame: next-base-update and vertical-compare. A single level interrupt output reports any cause that is both raised and unmasked. Software acknowledges a cause by writing ones to the clear register.

A build parameter selects the register-map variant. Variant 0 places the mask at word 6 and control at word 7. Variants 1 and 2 swap those two words. Variant 2 also reports different identification bytes.

The frame-tick machine has two states:
- `TK_IDLE`: no tick is counted.
- `TK_RUN`: the frame counter runs and wraps.

Its transitions are:
- start: `TK_IDLE` to `TK_RUN` on a control write with enable set.
- stop: `TK_RUN` to `TK_IDLE` on a control write with enable clear.
- restart: `TK_RUN` stays in `TK_RUN` and the count returns to zero on a control write with enable set.
- wrap: `TK_RUN` stays in `TK_RUN` when the count reaches `TICK_CYCLES-1`. This emits one tick and returns the count to zero.

Top module: `lcd_reg_unit`

## Requirements
- R1: While reset is held, and right after it is released, `irq` and `lcd_en` are low, and every register at word offsets 0 to 10 reads zero.
- R2: A read strobe at a clock edge loads `rd_data` and raises `rd_valid` at that edge. Words 0 to 3 (timing) and words 4 (upper base) and 5 (lower base) return all 32 bits last written.
- R3: Control fields:
  - Bit 0 is enable and drives `lcd_en`.
  - Bits [3:1] are the pixel depth and drive `pix_depth`.
  - Bit 8 drives `bgr_sel`.
  - Bit 9 drives `byte_be`.
  - Bit 10 drives `pixel_be`.
  - Bit 11 drives `lcd_power`.
  - All other control bits read zero.
- R4: With `MAP_VARIANT`=0, word 6 is the mask and word 7 is control. With any other variant the two words are swapped, for both reads and writes.
- R5: Words 0x3F8 to 0x3FF return one identification byte each in bits [7:0], with the upper bits zero.
  - Variants 0 and 1 return 10 11 04 00 0d f0 05 b1.
  - Variant 2 returns 11 11 24 00 0d f0 05 b1.
- R6: A control write with enable set arms the frame tick. Exactly `TICK_CYCLES` edges after that write, status bits 2 and 3 both become 1. The tick then repeats every `TICK_CYCLES` edges.
- R7: A control write with enable clear cancels the tick, and no cause is raised afterwards. A later enabling write counts a full `TICK_CYCLES` from zero.
- R8: Word 8 reads the raw status, with next-base at bit 2 and vertical-compare at bit 3. Writing word 10 clears each status bit whose data bit is 1. Word 10 reads zero.
- R9: If a tick and a clear of the same bit land on the same edge, the bit ends up set.
- R10: The mask keeps only bits 2 and 3; other bits read zero. `irq` is high exactly when some status bit and its mask bit are both 1. It follows mask writes and status changes on the same edge.
- R11: Reads of word 9, of words 11 to 0x3F7 and of word 10 return zero. Writes to word 9 and to words 11 to 0x3F7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (10) | Word offset in the window |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | rd_data holds a fresh read result |
| irq | output | 1 | Level interrupt |
| lcd_en | output | 1 | Controller enable |
| lcd_power | output | 1 | Panel power |
| pix_depth | output | 3 | Pixel depth mode |
| bgr_sel | output | 1 | BGR colour order |
| byte_be | output | 1 | Big-endian byte order |
| pixel_be | output | 1 | Big-endian pixel order in a byte |
| upper_base | output | 32 | Upper panel frame base |
| lower_base | output | 32 | Lower panel frame base |
| timing_flat | output | 128 | Four timing words, word 0 in the low bits |

## Verification
The two functions that can fall on the same clock edge are the frame tick setting both causes and a software write to the clear register. The bench arms the tick with a short period and counts edges from the enabling write. It then times a clear write so that the write is captured on the very edge of the second tick. Status read afterwards must be 0xC (set wins). An ordinary clear issued two edges later must then drop `irq` and leave status at zero.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;

    typedef enum logic [0:0] {
        TK_IDLE = 1'b0,
        TK_RUN  = 1'b1
    } tick_state_e;

    localparam int N_TIMING   = 4;
    localparam int N_ID       = 8;
    localparam int N_CAUSE    = 2;
    localparam int CAUSE_LSB  = 2;
    localparam int CTRL_W     = 12;
    localparam logic [CTRL_W-1:0] CTRL_KEEP = 12'hF0F;

    localparam int OFS_TIM0   = 0;
    localparam int OFS_UPBASE = 4;
    localparam int OFS_LPBASE = 5;
    localparam int OFS_SLOT_A = 6;
    localparam int OFS_SLOT_B = 7;
    localparam int OFS_STATUS = 8;
    localparam int OFS_CLEAR  = 10;

    // Identification byte idx for a map variant; variant 2 differs in bytes 0 and 2
    function automatic logic [7:0] id_byte(input int variant, input int idx);
        logic [7:0] b;
        unique case (idx)
            0:       b = (variant == 2) ? 8'h11 : 8'h10;
            1:       b = 8'h11;
            2:       b = (variant == 2) ? 8'h24 : 8'h04;
            3:       b = 8'h00;
            4:       b = 8'h0d;
            5:       b = 8'hf0;
            6:       b = 8'h05;
            default: b = 8'hb1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcdr_regs.sv
module lcdr_regs
    import lcdr_pkg::*;
#(
    parameter int MAP_VARIANT = 0,
    parameter int ADDR_W      = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [31:0]                   wdata,
    output logic [N_TIMING-1:0][31:0]     timing_q,
    output logic [31:0]                   upbase_q,
    output logic [31:0]                   lpbase_q,
    output logic [CTRL_W-1:0]             ctrl_q,
    output logic [N_CAUSE-1:0]            mask_q,
    output logic                          ctrl_wr,
    output logic                          rd_hit,
    output logic [31:0]                   rd_val
);

    localparam int CTRL_OFS = (MAP_VARIANT == 0) ? OFS_SLOT_B : OFS_SLOT_A;
    localparam int MASK_OFS = (MAP_VARIANT == 0) ? OFS_SLOT_A : OFS_SLOT_B;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] A_UP   = ADDR_W'(OFS_UPBASE);
    localparam logic [ADDR_W-1:0] A_LP   = ADDR_W'(OFS_LPBASE);

    logic mask_wr;

    assign ctrl_wr = wr_en && (addr == A_CTRL);
    assign mask_wr = wr_en && (addr == A_MASK);

    for (genvar g = 0; g < N_TIMING; g++) begin : g_tim
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                timing_q[g] <= '0;
            end else if (wr_en && (addr == ADDR_W'(OFS_TIM0 + g))) begin
                timing_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upbase_q <= '0;
            lpbase_q <= '0;
            ctrl_q   <= '0;
            mask_q   <= '0;
        end else begin
            if (wr_en && (addr == A_UP)) upbase_q <= wdata;
            if (wr_en && (addr == A_LP)) lpbase_q <= wdata;
            if (ctrl_wr)                 ctrl_q   <= wdata[CTRL_W-1:0] & CTRL_KEEP;
            if (mask_wr)                 mask_q   <= wdata[CAUSE_LSB +: N_CAUSE];
        end
    end

    always_comb begin
        rd_hit = 1'b1;
        rd_val = '0;
        if (addr == A_UP) begin
            rd_val = upbase_q;
        end else if (addr == A_LP) begin
            rd_val = lpbase_q;
        end else if (addr == A_CTRL) begin
            rd_val = 32'(ctrl_q);
        end else if (addr == A_MASK) begin
            rd_val = 32'(mask_q) << CAUSE_LSB;
        end else begin
            rd_hit = 1'b0;
            for (int i = 0; i < N_TIMING; i++) begin
                if (addr == ADDR_W'(OFS_TIM0 + i)) begin
                    rd_hit = 1'b1;
                    rd_val = timing_q[i];
                end
            end
        end
    end

endmodule

// File: rtl/lcdr_frame_tick.sv
module lcdr_frame_tick
    import lcdr_pkg::*;
#(
    parameter int TICK_CYCLES = 833_333
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic en_bit,
    output logic tick
);

    localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    tick_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TK_IDLE: if (ctrl_wr && en_bit)  state_d = TK_RUN;   // start
            TK_RUN:  if (ctrl_wr && !en_bit) state_d = TK_IDLE;  // stop
            default: state_d = TK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (ctrl_wr) begin
                cnt_q <= '0;                                   // restart
            end else if (state_q == TK_RUN) begin
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1); // wrap
            end
        end
    end

    always_comb begin
        tick = (state_q == TK_RUN) && (cnt_q == LAST) && !ctrl_wr;
    end

endmodule

// File: rtl/lcdr_irq.sv
module lcdr_irq
    import lcdr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               clr_wr,
    input  logic [N_CAUSE-1:0] clr_bits,
    input  logic [N_CAUSE-1:0] mask,
    output logic [N_CAUSE-1:0] raw_q,
    output logic               irq
);

    logic [N_CAUSE-1:0] drop, raise;

    assign drop  = clr_wr ? clr_bits : '0;
    assign raise = tick ? '1 : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= (raw_q & ~drop) | raise;
        end
    end

    assign irq = |(raw_q & mask);

endmodule

// File: rtl/lcd_reg_unit.sv
module lcd_reg_unit
    import lcdr_pkg::*;
#(
    parameter int MAP_VARIANT = 0,
    parameter int ADDR_W      = 10,
    parameter int TICK_CYCLES = 833_333
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rd_data,
    output logic                   rd_valid,
    output logic                   irq,
    output logic                   lcd_en,
    output logic                   lcd_power,
    output logic [2:0]             pix_depth,
    output logic                   bgr_sel,
    output logic                   byte_be,
    output logic                   pixel_be,
    output logic [31:0]            upper_base,
    output logic [31:0]            lower_base,
    output logic [N_TIMING*32-1:0] timing_flat
);

    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CLEAR   = ADDR_W'(OFS_CLEAR);
    localparam logic [ADDR_W-1:0] A_ID_BASE = ADDR_W'((1 << ADDR_W) - N_ID);

    logic [N_TIMING-1:0][31:0] timing_q;
    logic [CTRL_W-1:0]         ctrl_q;
    logic [N_CAUSE-1:0]        irq_mask;
    logic [N_CAUSE-1:0]        raw_status;
    logic                      ctrl_wr;
    logic                      regs_hit;
    logic [31:0]               regs_val;
    logic                      tick_pulse;
    logic                      clr_wr;
    logic [31:0]               rd_mux;

    lcdr_regs #(.MAP_VARIANT(MAP_VARIANT), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .timing_q (timing_q),
        .upbase_q (upper_base),
        .lpbase_q (lower_base),
        .ctrl_q   (ctrl_q),
        .mask_q   (irq_mask),
        .ctrl_wr  (ctrl_wr),
        .rd_hit   (regs_hit),
        .rd_val   (regs_val)
    );

    lcdr_frame_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .en_bit  (wdata[0]),
        .tick    (tick_pulse)
    );

    assign clr_wr = wr_en && (addr == A_CLEAR);

    lcdr_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_pulse),
        .clr_wr   (clr_wr),
        .clr_bits (wdata[CAUSE_LSB +: N_CAUSE]),
        .mask     (irq_mask),
        .raw_q    (raw_status),
        .irq      (irq)
    );

    assign lcd_en      = ctrl_q[0];
    assign pix_depth   = ctrl_q[3:1];
    assign bgr_sel     = ctrl_q[8];
    assign byte_be     = ctrl_q[9];
    assign pixel_be    = ctrl_q[10];
    assign lcd_power   = ctrl_q[11];
    assign timing_flat = timing_q;

    always_comb begin
        rd_mux = '0;
        if (regs_hit) begin
            rd_mux = regs_val;
        end else if (addr == A_STATUS) begin
            rd_mux = 32'(raw_status) << CAUSE_LSB;
        end else if (addr >= A_ID_BASE) begin
            rd_mux = {24'h0, id_byte(MAP_VARIANT, int'(addr[2:0]))};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/lcd_reg_unit_chk.sv
module lcd_reg_unit_chk
    import lcdr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [N_CAUSE-1:0] clr_data,
    input logic               rd_valid,
    input logic [31:0]        rd_data,
    input logic               irq,
    input logic               lcd_en,
    input logic               tick,
    input logic [N_CAUSE-1:0] raw_status,
    input logic [N_CAUSE-1:0] mask
);

    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLEAR);
    localparam logic [ADDR_W-1:0] A_HOLE = ADDR_W'(9);

    logic clr_hit;
    assign clr_hit = wr_en && (addr == A_CLR);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !irq); // R1

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R2

    AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> lcd_en); // R6

    AST_TICK_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (raw_status == '1)); // R9

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !tick) |=> ((raw_status & $past(clr_data)) == '0)); // R8

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_hit && !tick) |=> $stable(raw_status)); // R8

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq); // R10

    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_HOLE) |=> (rd_data == 32'h0)); // R11

endmodule

bind lcd_reg_unit lcd_reg_unit_chk #(.ADDR_W(ADDR_W)) chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .clr_data   (wdata[lcdr_pkg::CAUSE_LSB +: lcdr_pkg::N_CAUSE]),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .irq        (irq),
    .lcd_en     (lcd_en),
    .tick       (tick_pulse),
    .raw_status (raw_status),
    .mask       (irq_mask)
);

// File: tb/lcd_reg_unit_test.sv
`timescale 1ns/1ps
module lcd_reg_unit_test;

    localparam int AW   = 10;
    localparam int TICK = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;

    logic [31:0]  rd_data_a, rd_data_c, up_a, up_c, lp_a, lp_c;
    logic         rd_valid_a, rd_valid_c, irq_a, irq_c;
    logic         en_a, en_c, pwr_a, pwr_c, bgr_a, bgr_c, bbe_a, bbe_c, pbe_a, pbe_c;
    logic [2:0]   dep_a, dep_c;
    logic [127:0] tim_a, tim_c;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] exp_a;
        logic [31:0] exp_c;
        bit          chk_c;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    lcd_reg_unit #(.MAP_VARIANT(0), .ADDR_W(AW), .TICK_CYCLES(TICK)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data_a), .rd_valid(rd_valid_a), .irq(irq_a),
        .lcd_en(en_a), .lcd_power(pwr_a), .pix_depth(dep_a), .bgr_sel(bgr_a),
        .byte_be(bbe_a), .pixel_be(pbe_a), .upper_base(up_a), .lower_base(lp_a),
        .timing_flat(tim_a));

    lcd_reg_unit #(.MAP_VARIANT(2), .ADDR_W(AW), .TICK_CYCLES(TICK)) uut_c (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data_c), .rd_valid(rd_valid_c), .irq(irq_c),
        .lcd_en(en_c), .lcd_power(pwr_c), .pix_depth(dep_c), .bgr_sel(bgr_c),
        .byte_be(bbe_c), .pixel_be(pbe_c), .upper_base(up_c), .lower_base(lp_c),
        .timing_flat(tim_c));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] ea, input logic [31:0] ec,
                      input bit cc, input string tag);
        item_t it;
        it.exp_a = ea; it.exp_c = ec; it.chk_c = cc; it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: pops expected items as read results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid_a) begin
            if (sb_q.size() == 0) begin
                check("R2 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check({it.tag, " variant0"}, rd_data_a, it.exp_a);
                if (it.chk_c) check({it.tag, " variant2"}, rd_data_c, it.exp_c);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] id_a [8];
        logic [7:0] id_c [8];
        id_a = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0d, 8'hf0, 8'h05, 8'hb1};
        id_c = '{8'h11, 8'h11, 8'h24, 8'h00, 8'h0d, 8'hf0, 8'h05, 8'hb1};

        repeat (3) @(negedge clk);
        check("R1 irq in reset", 32'(irq_a), 0);
        check("R1 lcd_en in reset", 32'(en_a), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", 32'(irq_a), 0);
        for (int i = 0; i <= 10; i++) rd(i, 0, 0, 1, "R1 reset read");

        // R2 timing and base words
        for (int i = 0; i < 4; i++) wr(i, 32'hA500_0000 + 32'(i * 32'h0101_0013));
        wr(4, 32'hDEAD_BEE0);
        wr(5, 32'h1234_5678);
        for (int i = 0; i < 4; i++)
            rd(i, 32'hA500_0000 + 32'(i * 32'h0101_0013),
               32'hA500_0000 + 32'(i * 32'h0101_0013), 1, "R2 timing readback");
        rd(4, 32'hDEAD_BEE0, 32'hDEAD_BEE0, 1, "R2 upper base");
        rd(5, 32'h1234_5678, 32'h1234_5678, 1, "R2 lower base");
        check("R2 timing_flat word3", tim_a[127:96], 32'hA500_0000 + 32'(3 * 32'h0101_0013));
        check("R2 lower_base port", lp_a, 32'h1234_5678);

        // R3 and R4: word 7 is control on variant 0, mask on variant 2
        wr(7, 32'hFFFF_FFFE);
        rd(7, 32'h0000_0F0E, 32'h0000_000C, 1, "R3 R4 word7");
        rd(6, 32'h0, 32'h0, 1, "R4 word6 untouched");
        check("R3 pix_depth", 32'(dep_a), 7);
        check("R3 fields bgr/byte/pixel/power", {28'h0, bgr_a, bbe_a, pbe_a, pwr_a}, 32'hF);
        check("R3 lcd_en stays low", 32'(en_a), 0);
        wr(6, 32'h0000_0004);
        rd(6, 32'h4, 32'h4, 1, "R4 word6 write");
        check("R4 variant2 control at word6", 32'(dep_c), 2);
        rd(7, 32'h0000_0F0E, 32'h0000_000C, 1, "R4 word7 kept");

        // R5 identification bytes
        for (int i = 0; i < 8; i++)
            rd(32'h3F8 + i, {24'h0, id_a[i]}, {24'h0, id_c[i]}, 1, "R5 id byte");

        // R11 unmapped space
        wr(9, 32'hFFFF_FFFF);
        wr(32'h200, 32'hFFFF_FFFF);
        rd(9, 0, 0, 1, "R11 word9");
        rd(32'h200, 0, 0, 1, "R11 hole");
        rd(32'h3F7, 0, 0, 1, "R11 below id");
        rd(10, 0, 0, 1, "R11 clear reads zero");
        rd(7, 32'h0000_0F0E, 32'h0000_000C, 1, "R11 control unchanged");
        rd(5, 32'h1234_5678, 32'h1234_5678, 1, "R11 base unchanged");

        // R6 frame tick on variant 0
        wr(6, 32'h0000_000C);
        wr(7, 32'h0000_0001);
        check("R3 lcd_en set", 32'(en_a), 1);
        repeat (TICK - 1) @(negedge clk);
        check("R6 no tick before period", 32'(irq_a), 0);
        @(negedge clk);
        check("R6 R10 tick raises irq", 32'(irq_a), 1);
        repeat (TICK - 1) @(negedge clk);
        // R9: clear captured on the second tick edge
        wr(10, 32'h0000_000C);
        rd(8, 32'hC, 0, 0, "R9 set wins over clear");
        wr(10, 32'h0000_000C);
        check("R8 clear drops irq", 32'(irq_a), 0);
        rd(8, 32'h0, 0, 0, "R8 status cleared");

        // R7 stop then restart
        wr(7, 32'h0);
        repeat (3 * TICK) @(negedge clk);
        check("R7 no tick after stop", 32'(irq_a), 0);
        rd(8, 32'h0, 0, 0, "R7 status stays zero");
        wr(7, 32'h0000_0001);
        repeat (TICK - 1) @(negedge clk);
        check("R7 restart counts from zero", 32'(irq_a), 0);
        @(negedge clk);
        check("R7 tick after restart", 32'(irq_a), 1);

        // R10 mask gating, R8 per-bit clear
        wr(6, 32'h0);
        check("R10 masked off", 32'(irq_a), 0);
        rd(8, 32'hC, 0, 0, "R8 both causes set");
        wr(6, 32'hFFFF_FFF8);
        check("R10 vcompare unmasked", 32'(irq_a), 1);
        rd(6, 32'h8, 0, 0, "R10 mask keeps bits 2 and 3");
        wr(10, 32'h0000_0008);
        check("R8 R10 vcompare cleared", 32'(irq_a), 0);
        rd(8, 32'h4, 0, 0, "R8 next-base remains");
        wr(7, 32'h0);

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", 32'(sb_q.size()), 0);
        finish_run();
    end

endmodule